// File: doc/BRIEF.md
# Caller-ID Word Deframer with Three-Wire Host Output

This block sits behind an FSK demodulator in a caller-identification receiver. It takes the demodulated 1200-baud bit stream, finds asynchronous 8-bit characters in it and hands each one to a host over three wires: a serial data line, a data clock and an active-low data-ready strobe. The host therefore needs no UART, either in hardware or in software.

A mode input picks how the host receives the bits. In the streaming mode the block drives the data clock itself and presents every data bit as it is sampled. In the buffered mode the block holds the finished character and the host clocks it out at its own pace. The block also tracks the message: the second good character gives the number of body bytes that follow. Once the body and a trailing checksum byte have arrived, it lowers the demodulator enable so that later voice or tone energy cannot yield false characters. The enable also drops whenever carrier detect (active low) goes high.

The line rate is set by a parameter that holds the number of system clocks per bit.

Top module: `cid_deframer`

## Requirements
- R1: A character is one start bit at 0, 8 data bits least significant bit first, and a stop bit at 1. A good character makes `drN` fall, and in mode 0 (`modeSel`=0) `drN` stays low for exactly one clock.
- R2: A falling edge on `rxBit` starts a character only if the line is still 0 at the middle of the start bit. A low pulse shorter than half a bit yields no data clocks and no `drN` fall.
- R3: When the stop bit samples as 0, `frameErr` pulses high for one clock and `drN` does not fall.
- R4: Any run of 1 to 10 stop bits, and up to 20 further idle marks between characters, is accepted without creating extra characters or losing the next one.
- R5: In mode 0, each of the 8 data bits is placed on `dataOut` and `dclkOut` pulses high for one clock one cycle later, giving 8 pulses per character with the least significant bit first. In mode 1, `dclkOut` stays low.
- R6: In mode 1, after a good character `drN` goes low and `dataOut` shows bit 0. Each rising edge on `shiftClk` moves `dataOut` to the next bit, and `drN` returns high at the first rising edge.
- R7: The second good character of a message is the length L. `msgDone` rises after L+1 further good characters, and `demodEn` then goes low.
- R8: While `carrierN` is high, `demodEn` is low, the line is ignored, and the character count and `msgDone` are cleared.
- R9: After reset, `drN` is high, `dclkOut`, `frameErr` and `msgDone` are low, and `demodEn` is high when `carrierN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxBit | input | 1 | Demodulated bit stream (1 = mark) |
| carrierN | input | 1 | Carrier detect, low while carrier is present |
| modeSel | input | 1 | 0: block-clocked streaming, 1: host-clocked buffered |
| shiftClk | input | 1 | Host shift clock used in mode 1 |
| dataOut | output | 1 | Serial data to the host |
| dclkOut | output | 1 | Data clock driven in mode 0 |
| drN | output | 1 | Data ready, active low |
| frameErr | output | 1 | One-clock pulse when a stop bit samples 0 |
| msgDone | output | 1 | All announced bytes and the checksum have arrived |
| demodEn | output | 1 | Enable for the upstream demodulator |

## Verification
Every result is tied to the bit grid. A falling edge is seen two clocks after it reaches `rxBit`. The start bit is re-sampled half a bit after that, each data bit a full bit later, and the stop bit a full bit after the last data bit. `drN`, `frameErr` and the count update fall one or two clocks after the stop sample, which is well inside the stop bit. The data clock follows each data sample by two clocks. The bench drives whole bit periods and compares only after the final stop bit of each character has been sent, so every result is already due. A monitor samples at falling edges and records each one-clock pulse. In mode 1 the bench waits three clocks after each `shiftClk` edge before it reads `dataOut` and `drN`.

// File: rtl/cid_pkg.sv
package cid_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_t;

  // strobes passed from the framing control to the datapath
  typedef struct packed {
    logic sampleBit;  // a data bit was sampled this cycle
    logic bitVal;     // value of that bit
    logic wordGood;   // stop bit sampled as mark
    logic clearMsg;   // carrier absent: clear the message tracking
  } cid_strobe_t;

endpackage

// File: rtl/cid_control.sv
module cid_control
  import cid_pkg::*;
#(
  parameter int CLK_PER_BIT = 104167,
  parameter int WORD_BITS   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxBit,
  input  logic        carrierN,
  input  logic        modeSel,
  output cid_strobe_t strb,
  output logic        dclkOut,
  output logic        frameErr
);

  localparam int HALF_BIT = CLK_PER_BIT / 2;
  localparam int TICK_W   = $clog2(CLK_PER_BIT + 1);
  localparam int IDX_W    = $clog2(WORD_BITS);

  rx_state_t          state;
  logic [TICK_W-1:0]  tick;
  logic [IDX_W-1:0]   bitIdx;
  logic               rxQ, rxPrev, dclkArm;
  logic               halfDone, fullDone;

  assign halfDone = (tick == TICK_W'(HALF_BIT - 1));
  assign fullDone = (tick == TICK_W'(CLK_PER_BIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tick     <= '0;
      bitIdx   <= '0;
      rxQ      <= 1'b1;
      rxPrev   <= 1'b1;
      strb     <= '0;
      dclkArm  <= 1'b0;
      dclkOut  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      rxQ           <= rxBit;
      rxPrev        <= rxQ;
      strb          <= '0;
      strb.clearMsg <= carrierN;
      dclkArm       <= strb.sampleBit && !modeSel;
      dclkOut       <= dclkArm && !modeSel;
      frameErr      <= 1'b0;
      if (carrierN) begin
        state <= ST_IDLE;
        tick  <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            tick <= '0;
            if (rxPrev && !rxQ) state <= ST_START;
          end
          ST_START: begin
            if (halfDone) begin
              tick   <= '0;
              bitIdx <= '0;
              state  <= rxQ ? ST_IDLE : ST_DATA;
            end else tick <= tick + 1'b1;
          end
          ST_DATA: begin
            if (fullDone) begin
              tick           <= '0;
              strb.sampleBit <= 1'b1;
              strb.bitVal    <= rxQ;
              bitIdx         <= bitIdx + 1'b1;
              if (bitIdx == IDX_W'(WORD_BITS - 1)) state <= ST_STOP;
            end else tick <= tick + 1'b1;
          end
          ST_STOP: begin
            if (fullDone) begin
              tick  <= '0;
              state <= ST_IDLE;
              if (rxQ) strb.wordGood <= 1'b1;
              else     frameErr      <= 1'b1;
            end else tick <= tick + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R8: a high carrierN forces the framer back to idle
  assert_idle_no_carrier_R8: assert property (@(posedge clk) disable iff (!rstN)
    carrierN |=> (state == ST_IDLE));

  // R2: data phase is entered only from a start bit that was low at mid-bit
  assert_start_revalidated_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && $past(state) == ST_START) |-> !$past(rxQ));

  // R5: each data clock pulse follows a datapath sample strobe
  assert_dclk_after_sample_R5: assert property (@(posedge clk) disable iff (!rstN)
    dclkOut |-> $past(strb.sampleBit, 2));

endmodule

// File: rtl/cid_datapath.sv
module cid_datapath
  import cid_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  cid_strobe_t strb,
  input  logic        modeSel,
  input  logic        shiftClk,
  input  logic        carrierN,
  output logic        dataOut,
  output logic        drN,
  output logic        msgDone,
  output logic        demodEn
);

  localparam int CNT_W   = WORD_BITS + 1;
  localparam int LEN_IDX = 1;               // second good word carries the length
  localparam int OVERHEAD = 3;              // type + length + checksum

  logic [WORD_BITS-1:0] rxShift, outShift, lenReg;
  logic [CNT_W-1:0]     byteCnt, cntNext, target;
  logic                 bitOut, shQ, shPrev, shiftRise;

  assign shiftRise = shQ && !shPrev;
  assign cntNext   = byteCnt + 1'b1;
  assign target    = {1'b0, lenReg} + CNT_W'(OVERHEAD);
  assign dataOut   = modeSel ? outShift[0] : bitOut;
  assign demodEn   = !carrierN && !msgDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      outShift <= '0;
      lenReg   <= '0;
      byteCnt  <= '0;
      bitOut   <= 1'b0;
      shQ      <= 1'b0;
      shPrev   <= 1'b0;
      drN      <= 1'b1;
      msgDone  <= 1'b0;
    end else begin
      shQ    <= shiftClk;
      shPrev <= shQ;

      if (strb.sampleBit) begin
        rxShift <= {strb.bitVal, rxShift[WORD_BITS-1:1]};
        bitOut  <= strb.bitVal;
      end

      if (strb.wordGood)               outShift <= rxShift;
      else if (modeSel && shiftRise)   outShift <= outShift >> 1;

      if (strb.wordGood)               drN <= 1'b0;
      else if (!modeSel || shiftRise)  drN <= 1'b1;

      if (strb.clearMsg) begin
        byteCnt <= '0;
        msgDone <= 1'b0;
      end else if (strb.wordGood) begin
        if (byteCnt != '1) byteCnt <= cntNext;
        if (byteCnt == CNT_W'(LEN_IDX)) lenReg <= rxShift;
        if (byteCnt > CNT_W'(LEN_IDX) && cntNext == target) msgDone <= 1'b1;
      end
    end
  end

  // R1: drN only falls right after a good-word strobe
  assert_dr_after_word_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drN) |-> $past(strb.wordGood));

  // R1: in mode 0 the ready strobe is a single clock wide
  assert_dr_width_mode0_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && !drN) |=> drN);

  // R6: in mode 1 ready is released only by a host shift edge
  assert_mode1_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && $past(modeSel) && $rose(drN)) |-> $past(shiftRise));

  // R7: completion holds until carrier loss clears it
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msgDone && !strb.clearMsg) |=> msgDone);

endmodule

// File: rtl/cid_deframer.sv
module cid_deframer
  import cid_pkg::*;
#(
  parameter int CLK_PER_BIT = 104167,
  parameter int WORD_BITS   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxBit,
  input  logic carrierN,
  input  logic modeSel,
  input  logic shiftClk,
  output logic dataOut,
  output logic dclkOut,
  output logic drN,
  output logic frameErr,
  output logic msgDone,
  output logic demodEn
);

  cid_strobe_t strb;

  cid_control #(.CLK_PER_BIT(CLK_PER_BIT), .WORD_BITS(WORD_BITS)) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .rxBit    (rxBit),
    .carrierN (carrierN),
    .modeSel  (modeSel),
    .strb     (strb),
    .dclkOut  (dclkOut),
    .frameErr (frameErr)
  );

  cid_datapath #(.WORD_BITS(WORD_BITS)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .modeSel  (modeSel),
    .shiftClk (shiftClk),
    .carrierN (carrierN),
    .dataOut  (dataOut),
    .drN      (drN),
    .msgDone  (msgDone),
    .demodEn  (demodEn)
  );

endmodule

// File: tb/test_cid_deframer.sv
module test_cid_deframer;

  localparam int BITC = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxBit = 1'b1;
  logic carrierN = 1'b0;
  logic modeSel = 1'b0;
  logic shiftClk = 1'b0;
  logic dataOut, dclkOut, drN, frameErr, msgDone, demodEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  int drFalls = 0, dclkPulses = 0, errPulses = 0;
  logic [7:0] monShift = '0, lastWord = '0;
  logic drPrev = 1'b1;

  always #4 clk = ~clk;  // 125 MHz

  cid_deframer #(.CLK_PER_BIT(BITC), .WORD_BITS(8)) i_cid_deframer (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .carrierN(carrierN),
    .modeSel(modeSel), .shiftClk(shiftClk), .dataOut(dataOut),
    .dclkOut(dclkOut), .drN(drN), .frameErr(frameErr),
    .msgDone(msgDone), .demodEn(demodEn)
  );

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (dclkOut) begin
      dclkPulses++;
      monShift = {dataOut, monShift[7:1]};
    end
    if (frameErr) errPulses++;
    if (drPrev && !drN) begin
      drFalls++;
      lastWord = monShift;
    end
    drPrev = drN;
  end

  task automatic check(input int actual, input int expected, input string tag);
    nChecks++;
    if (actual !== expected) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  task automatic sendBit(input logic b);
    rxBit = b;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic sendWord(input logic [7:0] w, input int nStop, input logic stopVal);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(w[i]);
    sendBit(stopVal);
    for (int i = 1; i < nStop; i++) sendBit(1'b1);
    if (!stopVal) sendBit(1'b1);
    repeat (2) @(negedge clk);
  endtask

  task automatic clearCarrier();
    carrierN = 1'b1;
    repeat (4) @(negedge clk);
    carrierN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check(drN, 1, "R9 drN after reset");
    check(dclkOut, 0, "R9 dclkOut after reset");
    check(frameErr, 0, "R9 frameErr after reset");
    check(msgDone, 0, "R9 msgDone after reset");
    check(demodEn, 1, "R9 demodEn after reset");
  endtask

  task automatic testSingleWord();
    int f0 = drFalls, d0 = dclkPulses;
    sendWord(8'h3C, 1, 1'b1);
    check(drFalls - f0, 1, "R1 one ready strobe per word");
    check(lastWord, 8'h3C, "R1 word value LSB first");
    check(dclkPulses - d0, 8, "R5 eight data clocks per word");
    check(drN, 1, "R1 ready returned high in mode 0");
  endtask

  task automatic testGlitch();
    int f0 = drFalls, d0 = dclkPulses;
    rxBit = 1'b0;
    repeat (4) @(negedge clk);
    rxBit = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    check(dclkPulses - d0, 0, "R2 short low pulse gives no data clocks");
    check(drFalls - f0, 0, "R2 short low pulse gives no word");
  endtask

  task automatic testFrameError();
    int f0 = drFalls, e0 = errPulses;
    sendWord(8'h55, 1, 1'b0);
    check(errPulses - e0, 1, "R3 framing error pulse");
    check(drFalls - f0, 0, "R3 no ready on bad stop");
  endtask

  task automatic testStopRuns();
    int f0;
    clearCarrier();
    f0 = drFalls;
    sendWord(8'h12, 1, 1'b1);
    check(lastWord, 8'h12, "R4 word after one stop");
    sendWord(8'hF0, 10, 1'b1);
    check(lastWord, 8'hF0, "R4 word with ten stops");
    sendWord(8'h00, 1, 1'b1);
    check(lastWord, 8'h00, "R4 word after ten stops");
    for (int i = 0; i < 20; i++) sendBit(1'b1);
    sendWord(8'h81, 1, 1'b1);
    check(lastWord, 8'h81, "R4 word after twenty extra marks");
    check(drFalls - f0, 4, "R4 no extra words from marks");
  endtask

  task automatic testLength();
    clearCarrier();
    sendWord(8'h80, 1, 1'b1);
    sendWord(8'h03, 2, 1'b1);
    sendWord(8'h11, 1, 1'b1);
    sendWord(8'h22, 1, 1'b1);
    sendWord(8'h33, 3, 1'b1);
    check(msgDone, 0, "R7 not done before checksum");
    check(demodEn, 1, "R7 enable held before checksum");
    sendWord(8'h66, 1, 1'b1);
    check(msgDone, 1, "R7 done after length plus checksum");
    check(demodEn, 0, "R7 enable dropped when done");
  endtask

  task automatic testCarrier();
    int f0;
    carrierN = 1'b1;
    repeat (4) @(negedge clk);
    check(msgDone, 0, "R8 done cleared by carrier loss");
    check(demodEn, 0, "R8 enable low without carrier");
    f0 = drFalls;
    sendWord(8'h5A, 1, 1'b1);
    check(drFalls - f0, 0, "R8 line ignored without carrier");
    carrierN = 1'b0;
    repeat (4) @(negedge clk);
    check(demodEn, 1, "R8 enable back with carrier");
  endtask

  task automatic testMode1();
    logic [7:0] w = 8'hA3;
    int d0;
    modeSel = 1'b1;
    repeat (4) @(negedge clk);
    d0 = dclkPulses;
    sendWord(w, 1, 1'b1);
    check(drN, 0, "R6 ready held low in mode 1");
    check(dclkPulses - d0, 0, "R5 no data clock in mode 1");
    for (int i = 0; i < 8; i++) begin
      check(dataOut, w[i], "R6 host-shifted bit");
      shiftClk = 1'b1;
      repeat (3) @(negedge clk);
      if (i == 0) check(drN, 1, "R6 ready released by first shift edge");
      shiftClk = 1'b0;
      repeat (3) @(negedge clk);
    end
    modeSel = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testSingleWord();
    testGlitch();
    testFrameError();
    testStopRuns();
    testLength();
    testCarrier();
    testMode1();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule